// File: doc/BRIEF.md
# Three-Channel Compare Interval Timer

This block is an up-counter with a word-addressed register port and one interrupt line. It counts pulses from one of three tick-enable inputs that run in the bus clock domain. A 12-bit prescaler divides the selected pulse stream. Three compare registers are checked against the counter as it advances. Each match sets a status flag, and a wrap of the counter from all-ones sets a rollover flag. The interrupt line is high while an enabled flag is pending and the timer is running.

There are two counting modes. In restart mode the counter goes back to zero on the step after it reaches compare 1. Writing compare 1 in this mode also restarts the count. In free-run mode the counter runs through its whole range and wraps. A soft reset through the control register sets the registers back to their reset values, but it keeps the clock-source and mode selection. Enabling the timer with the enable-mode bit set starts the count again from zero.

Top module: `tri_cmp_timer`

## Requirements
- R1: After hard reset, the control, prescaler, status and interrupt-enable registers and the counter read 0, the three compare registers read all-ones (CNT_W bits, zero-extended to 32), and `irq` is low.
- R2: Word addresses are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture, 9 counter. Capture words, word 10 and higher always read 0. Writes to words 7 to 15 change no register.
- R3: Control bits 2, 4 and 10 to 14 are not stored and read 0. The other bits are stored and read back. Bit 0 is enable, bit 1 enable-mode, bits 8:6 clock source, bit 9 free-run. Bit 15 (soft reset) reads 1 in the cycle after it is written and 0 after that.
- R4: Clock-source code 001 counts `tickPeriph`, 010 counts `tickHigh` and 100 counts `tickSlow`. Any other code, or enable = 0, holds the counter.
- R5: The prescaler stores 12 bits. The counter advances once every (prescaler + 1) selected ticks.
- R6: In restart mode (bit 9 = 0), a step taken while the counter equals compare 1 loads 0.
- R7: In free-run mode, a step from all-ones loads 0 and sets status bit 5 (rollover).
- R8: A step that makes the counter equal to compare N sets status bit N-1 (bits 0 to 2). Status bits 3 and 4 never set.
- R9: Writing status clears each bit written as 1. A flag set in the same cycle as the clear wins over it. Interrupt enable stores only bits 5:0.
- R10: `irq` is high exactly when (status AND interrupt-enable) is nonzero and the enable bit is 1.
- R11: Writing compare 1 in restart mode sets the counter and prescaler to 0. In free-run mode the same write leaves the count running.
- R12: A control write with bit 15 set clears enable, enable-mode and bits 3 and 5. It keeps the other written control bits. It resets the prescaler, status, interrupt-enable and counter to 0 and the compares to all-ones.
- R13: A control write that sets enable from 0 with enable-mode = 1 zeroes the counter. Without enable-mode, the count resumes from its held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| busSel | input | 1 | Register access select |
| busWe | input | 1 | Write strobe, qualified by busSel |
| busAddr | input | ADDR_W | Word address (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, 0 when busSel is low |
| tickPeriph | input | 1 | Peripheral-clock tick pulse |
| tickHigh | input | 1 | High-frequency tick pulse |
| tickSlow | input | 1 | 32 kHz tick pulse |
| irq | output | 1 | Interrupt request |

## Verification
The counter is driven by each of the three tick inputs in turn and by an undefined source code. This shows whether the source decode routes the right pulse or holds the count. A prescaler of 2 against a steady tick stream shows whether the divider advances once every third tick or gets the count wrong by one. Restart and free-run runs start from the same compare values, so a match that reloads zero can be told apart from one that only raises a flag. A full free-run sweep to the wrap separates the compare flags, which set when all-ones is reached, from the rollover flag, which sets one step later. A status clear timed onto a match cycle shows which side has priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W  = 12;
  localparam int FLAG_W = 6;
  localparam int N_CMP  = 3;

  localparam int W_CTRL = 0;
  localparam int W_PRE  = 1;
  localparam int W_STAT = 2;
  localparam int W_IEN  = 3;
  localparam int W_CMP0 = 4;
  localparam int W_CNT  = 9;

  localparam int B_EN    = 0;
  localparam int B_ENMOD = 1;
  localparam int B_FREE  = 9;
  localparam int B_SWR   = 15;
  localparam int B_ROLL  = 5;

  localparam logic [31:0] CTRL_DROP = 32'h0000_7C14;
  localparam logic [31:0] SOFT_CLR  = 32'h0000_003F;

  typedef struct packed {
    logic             run;
    logic [2:0]       srcSel;
    logic             freeRun;
    logic             restart;
    logic [PRE_W-1:0] presc;
  } dpCtrl_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtrl_t                       dp,
  input  logic [N_CMP-1:0][CNT_W-1:0]   cmpVal,
  input  logic [2:0]                    tickVec,
  output logic [CNT_W-1:0]              count,
  output logic [N_CMP-1:0]              hitVec,
  output logic                          rollEv
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             srcTick;
  logic [PRE_W-1:0] preCnt;
  logic             step;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    unique case (dp.srcSel)
      3'b001:  srcTick = tickVec[0];
      3'b010:  srcTick = tickVec[1];
      3'b100:  srcTick = tickVec[2];
      default: srcTick = 1'b0;
    endcase
  end

  assign step    = dp.run && srcTick && (preCnt >= dp.presc) && !dp.restart;
  assign nextCnt = (!dp.freeRun && count == cmpVal[0]) ? '0 : count + 1'b1;
  assign rollEv  = step && (count == CNT_MAX);

  generate
    for (genvar i = 0; i < N_CMP; i++) begin : g_hit
      assign hitVec[i] = step && (nextCnt == cmpVal[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      preCnt <= '0;
    end else if (dp.restart) begin
      count  <= '0;
      preCnt <= '0;
    end else if (dp.run && srcTick) begin
      if (preCnt >= dp.presc) begin
        preCnt <= '0;
        count  <= nextCnt;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!(dp.run && srcTick) && !dp.restart) |=> $stable(count));

  p_free_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (step && dp.freeRun && count != CNT_MAX) |=> count == $past(count) + 1'b1);

  p_restart_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    dp.restart |=> count == '0);

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (step && !dp.freeRun && count == cmpVal[0]) |=> count == '0);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [31:0]                   busWdata,
  output logic [31:0]                   busRdata,
  output logic                          irq,
  output dpCtrl_t                       dp,
  output logic [N_CMP-1:0][CNT_W-1:0]   cmpVal,
  input  logic [CNT_W-1:0]              count,
  input  logic [N_CMP-1:0]              hitVec,
  input  logic                          rollEv
);
  localparam logic [31:0] SWR_BIT = 32'h1 << B_SWR;
  localparam logic [31:0] KEEP    = ~CTRL_DROP & ~SWR_BIT;

  logic [31:0]       ctrlReg;
  logic              swrFlag;
  logic [PRE_W-1:0]  prescReg;
  logic [FLAG_W-1:0] statReg;
  logic [FLAG_W-1:0] ienReg;

  logic              wrEn, wrCtrl, wrPre, wrStat, wrIen, swrReq, enRise;
  logic [N_CMP-1:0]  wrCmp;
  logic [FLAG_W-1:0] setMask, clrMask;

  assign wrEn   = busSel && busWe;
  assign wrCtrl = wrEn && (busAddr == ADDR_W'(W_CTRL));
  assign wrPre  = wrEn && (busAddr == ADDR_W'(W_PRE));
  assign wrStat = wrEn && (busAddr == ADDR_W'(W_STAT));
  assign wrIen  = wrEn && (busAddr == ADDR_W'(W_IEN));
  assign swrReq = wrCtrl && busWdata[B_SWR];
  assign enRise = wrCtrl && busWdata[B_EN] && busWdata[B_ENMOD] && !ctrlReg[B_EN];

  always_comb begin
    for (int i = 0; i < N_CMP; i++)
      wrCmp[i] = wrEn && (busAddr == ADDR_W'(W_CMP0 + i));
  end

  assign setMask = {rollEv, 2'b00, hitVec};
  assign clrMask = wrStat ? busWdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      swrFlag  <= 1'b0;
      prescReg <= '0;
      statReg  <= '0;
      ienReg   <= '0;
      cmpVal   <= '1;
    end else begin
      swrFlag <= swrReq;
      if (swrReq) begin
        ctrlReg  <= busWdata & KEEP & ~SOFT_CLR;
        prescReg <= '0;
        statReg  <= '0;
        ienReg   <= '0;
        cmpVal   <= '1;
      end else begin
        if (wrCtrl) ctrlReg  <= busWdata & KEEP;
        if (wrPre)  prescReg <= busWdata[PRE_W-1:0];
        if (wrIen)  ienReg   <= busWdata[FLAG_W-1:0];
        statReg <= (statReg & ~clrMask) | setMask;
        for (int i = 0; i < N_CMP; i++)
          if (wrCmp[i]) cmpVal[i] <= busWdata[CNT_W-1:0];
      end
    end
  end

  assign dp.run     = ctrlReg[B_EN];
  assign dp.srcSel  = ctrlReg[8:6];
  assign dp.freeRun = ctrlReg[B_FREE];
  assign dp.presc   = prescReg;
  assign dp.restart = swrReq || enRise || (wrCmp[0] && !ctrlReg[B_FREE]);

  assign irq = (|(statReg & ienReg)) && ctrlReg[B_EN];

  always_comb begin
    busRdata = '0;
    if (busSel) begin
      case (busAddr)
        ADDR_W'(W_CTRL):     busRdata = ctrlReg | (swrFlag ? SWR_BIT : 32'h0);
        ADDR_W'(W_PRE):      busRdata = 32'(prescReg);
        ADDR_W'(W_STAT):     busRdata = 32'(statReg);
        ADDR_W'(W_IEN):      busRdata = 32'(ienReg);
        ADDR_W'(W_CMP0):     busRdata = 32'(cmpVal[0]);
        ADDR_W'(W_CMP0 + 1): busRdata = 32'(cmpVal[1]);
        ADDR_W'(W_CMP0 + 2): busRdata = 32'(cmpVal[2]);
        ADDR_W'(W_CNT):      busRdata = 32'(count);
        default:             busRdata = '0;
      endcase
    end
  end

  p_hit_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec[0] && !swrReq) |=> statReg[0]);

  p_roll_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rollEv && !swrReq) |=> statReg[B_ROLL]);

  p_soft_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    swrReq |=> (ctrlReg[5:0] == 6'd0 && swrFlag && statReg == '0));

  p_capture_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    statReg[4:3] == 2'b00);
endmodule

// File: rtl/tri_cmp_timer.sv
module tri_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              tickPeriph,
  input  logic              tickHigh,
  input  logic              tickSlow,
  output logic              irq
);
  dpCtrl_t                     dp;
  logic [N_CMP-1:0][CNT_W-1:0] cmpVal;
  logic [CNT_W-1:0]            count;
  logic [N_CMP-1:0]            hitVec;
  logic                        rollEv;

  tmr_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .dp(dp),
    .cmpVal(cmpVal), .count(count), .hitVec(hitVec), .rollEv(rollEv)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .dp(dp), .cmpVal(cmpVal),
    .tickVec({tickSlow, tickHigh, tickPeriph}),
    .count(count), .hitVec(hitVec), .rollEv(rollEv)
  );
endmodule

// File: tb/tri_cmp_timer_test.sv
`timescale 1ns/1ps
module tri_cmp_timer_test;
  localparam int CW = 16;
  localparam logic [31:0] MAXV = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickPeriph = 1'b0, tickHigh = 1'b0, tickSlow = 1'b0;
  logic        irq;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tri_cmp_timer #(.CNT_W(CW), .ADDR_W(4)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickPeriph(tickPeriph),
    .tickHigh(tickHigh), .tickSlow(tickSlow), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rdCheck(input string req, input logic [3:0] a, input logic [31:0] exp);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1;
    check(req, busRdata, exp);
    busSel = 1'b0;
  endtask

  task automatic testReset();
    rdCheck("R1 ctrl", 4'd0, 0);
    rdCheck("R1 presc", 4'd1, 0);
    rdCheck("R1 status", 4'd2, 0);
    rdCheck("R1 ien", 4'd3, 0);
    rdCheck("R1 cmp1", 4'd4, MAXV);
    rdCheck("R1 cmp2", 4'd5, MAXV);
    rdCheck("R1 cmp3", 4'd6, MAXV);
    rdCheck("R1 count", 4'd9, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic testMap();
    wr(4'd0, 32'h0000_7FFE);
    rdCheck("R3 ctrl mask", 4'd0, 32'h0000_03EA);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h0000_FFFF);
    rdCheck("R9 ien mask", 4'd3, 32'h3F);
    wr(4'd3, 32'h0);
    wr(4'd7, 32'h99);
    rdCheck("R2 capture1", 4'd7, 0);
    rdCheck("R2 capture2", 4'd8, 0);
    wr(4'd10, 32'h55);
    rdCheck("R2 word10", 4'd10, 0);
    wr(4'd9, 32'h1234);
    rdCheck("R2 count read-only", 4'd9, 0);
  endtask

  task automatic testSource();
    wr(4'd0, 32'h8000);
    tickPeriph = 1'b1;
    wr(4'd0, 32'h2C1);
    waitCyc(5);
    rdCheck("R4 undefined source holds", 4'd9, 0);
    wr(4'd0, 32'h2C0);
    wr(4'd0, 32'h8000);
    tickPeriph = 1'b0; tickHigh = 1'b1;
    wr(4'd0, 32'h281);
    waitCyc(4);
    rdCheck("R4 high source", 4'd9, 4);
    wr(4'd0, 32'h280);
    tickHigh = 1'b0; tickSlow = 1'b1;
    wr(4'd0, 32'h301);
    waitCyc(3);
    rdCheck("R13 slow source resumes", 4'd9, 8);
    wr(4'd0, 32'h300);
    tickSlow = 1'b0;
    rdCheck("R4 disabled", 4'd9, 9);
  endtask

  task automatic testPresc();
    wr(4'd0, 32'h8000);
    tickPeriph = 1'b1;
    wr(4'd1, 32'd2);
    wr(4'd0, 32'h241);
    waitCyc(9);
    rdCheck("R5 divide by 3", 4'd9, 3);
    wr(4'd0, 32'h240);
    rdCheck("R5 mid-period hold", 4'd9, 3);
    wr(4'd1, 32'h1FFF);
    rdCheck("R5 presc width", 4'd1, 32'hFFF);
  endtask

  task automatic testEnMod();
    wr(4'd0, 32'h8000);
    wr(4'd0, 32'h241);
    waitCyc(5);
    rdCheck("R13 run", 4'd9, 5);
    wr(4'd0, 32'h240);
    rdCheck("R13 stop", 4'd9, 6);
    wr(4'd0, 32'h241);
    waitCyc(2);
    rdCheck("R13 resume", 4'd9, 8);
    wr(4'd0, 32'h240);
    wr(4'd0, 32'h243);
    rdCheck("R13 enable-mode zero", 4'd9, 0);
    waitCyc(3);
    rdCheck("R13 after zero", 4'd9, 3);
    wr(4'd0, 32'h240);
  endtask

  task automatic testRestart();
    wr(4'd0, 32'h8000);
    wr(4'd4, 32'd4);
    wr(4'd3, 32'h01);
    wr(4'd0, 32'h41);
    waitCyc(6);
    rdCheck("R6 restart at cmp1", 4'd9, 1);
    rdCheck("R8 cmp1 flag", 4'd2, 32'h01);
    check("R10 irq high", 32'(irq), 1);
    wr(4'd2, 32'h01);
    rdCheck("R9 w1c", 4'd2, 0);
    check("R10 irq low", 32'(irq), 0);
    wr(4'd4, 32'd100);
    rdCheck("R11 cmp1 write restarts", 4'd9, 0);
    waitCyc(3);
    rdCheck("R11 counting after", 4'd9, 3);
    wr(4'd0, 32'h241);
    wr(4'd4, 32'd200);
    rdCheck("R11 free-run no restart", 4'd9, 5);
    wr(4'd0, 32'h240);
  endtask

  task automatic testChannels();
    wr(4'd0, 32'h8200);
    wr(4'd5, 32'd10);
    wr(4'd6, 32'd20);
    wr(4'd0, 32'h241);
    waitCyc(10);
    rdCheck("R8 cmp2 flag", 4'd2, 32'h02);
    waitCyc(10);
    rdCheck("R8 cmp3 flag", 4'd2, 32'h06);
    rdCheck("R8 count at cmp3", 4'd9, 20);
    check("R10 irq masked", 32'(irq), 0);
    wr(4'd3, 32'h04);
    check("R10 irq enabled flag", 32'(irq), 1);
    wr(4'd0, 32'h240);
    check("R10 irq gated by enable", 32'(irq), 0);
    wr(4'd2, 32'h3F);
    rdCheck("R9 clear all", 4'd2, 0);
  endtask

  task automatic testSetWins();
    wr(4'd0, 32'h8200);
    wr(4'd5, 32'd5);
    wr(4'd0, 32'h241);
    waitCyc(4);
    wr(4'd2, 32'h02);
    rdCheck("R9 set beats clear", 4'd2, 32'h02);
    rdCheck("R9 count at hit", 4'd9, 5);
    wr(4'd0, 32'h240);
  endtask

  task automatic testWrap();
    wr(4'd0, 32'h8200);
    wr(4'd3, 32'h20);
    wr(4'd0, 32'h241);
    waitCyc(65535);
    rdCheck("R7 at all-ones", 4'd9, MAXV);
    rdCheck("R8 compare at max", 4'd2, 32'h07);
    check("R7 irq before wrap", 32'(irq), 0);
    waitCyc(1);
    rdCheck("R7 wrapped", 4'd9, 0);
    rdCheck("R7 rollover flag", 4'd2, 32'h27);
    check("R7 irq on rollover", 32'(irq), 1);
    wr(4'd0, 32'h240);
  endtask

  task automatic testSoft();
    wr(4'd0, 32'h241);
    waitCyc(3);
    wr(4'd1, 32'd5);
    wr(4'd3, 32'h3F);
    wr(4'd6, 32'd9);
    wr(4'd0, 32'h82EB);
    rdCheck("R12 ctrl kept bits", 4'd0, 32'h82C0);
    waitCyc(1);
    rdCheck("R3 soft bit self-clears", 4'd0, 32'h02C0);
    rdCheck("R12 presc", 4'd1, 0);
    rdCheck("R12 status", 4'd2, 0);
    rdCheck("R12 ien", 4'd3, 0);
    rdCheck("R12 cmp3", 4'd6, MAXV);
    rdCheck("R12 count", 4'd9, 0);
    check("R12 irq", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMap();
    testSource();
    testPresc();
    testEnMod();
    testRestart();
    testChannels();
    testSetWins();
    testWrap();
    testSoft();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule